// File: doc/BRIEF.md
# I2C Master Status and Interrupt Collector

This block gathers the event pulses and levels produced by an I2C master byte engine, its bus monitor and its two small FIFOs, and presents them as one registered 16-bit read-only status word. Some flags are live levels: bus busy, master busy, transmit request and transmit FIFO fill. Others are sticky records of an event: transfer done, the two NACK kinds, arbitration lost, receive request and receive overflow. A read strobe from the bus side clears the sticky flags once software has seen them.

A single interrupt line is formed from five source groups. Each group has its own enable bit. The line is registered, so it responds one clock after the flag that drives it. The bit-level SCL/SDA engine and the register decode sit outside this block.

Top module: `i2cm_status_top`

## Requirements
- R1: After reset the status word is 0x0000 and the interrupt is low; bits 15..11 read zero at all times.
- R2: Bit 10 (bus busy) becomes 1 the clock after `startSeen` and 0 the clock after `stopSeen`; when both pulse together it becomes 1.
- R3: Bit 9 (receive overflow) becomes 1 the clock after `rxWrite` is high while `rxFull` is high, and it stays set until it is cleared by a read.
- R4: A `statusRead` pulse clears bits 9, 8, 7, 5, 4 and 3 on the next clock, unless that flag's own set event is present in the same cycle, in which case the flag stays 1.
- R5: Bit 8 (transfer complete) becomes 1 the clock after `xferDone`.
- R6: Bit 7 becomes 1 the clock after `dataNack`, and bit 4 becomes 1 the clock after `addrNack`.
- R7: Bit 5 becomes 1 the clock after `arbLost`; bit 6 equals `masterBusy` delayed by one clock.
- R8: Bit 3 (receive request) becomes 1 the clock after `rxWrite` is high with `rxFull` low; a write into a full FIFO does not set it.
- R9: Bit 2 (transmit request) equals, one clock later, `addrWriteSent` AND (`txCount` <= 1).
- R10: Bits 1..0 show `txCount` one clock later, encoded as 0 -> 00, 1 -> 01, 2 (full) -> 11; code 10 never appears.
- R11: `irq` is registered. One clock after any enabled source is set it is high, where the sources map onto the enable bits as `intEnable[0]`=bit 2, [1]=bit 3, [2]=bit 7 or bit 4, [3]=bit 5, [4]=bit 8. Bit 9 never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | Start condition seen on the bus (pulse) |
| stopSeen | input | 1 | Stop condition seen on the bus (pulse) |
| xferDone | input | 1 | Transaction with the slave finished (pulse) |
| addrNack | input | 1 | Address byte not acknowledged (pulse) |
| dataNack | input | 1 | Written data byte not acknowledged (pulse) |
| arbLost | input | 1 | Arbitration lost (pulse) |
| masterBusy | input | 1 | Master is processing a transaction (level) |
| addrWriteSent | input | 1 | Address with write direction sent in this transaction (level) |
| txCount | input | 2 | Transmit FIFO occupancy, 0 to 2 |
| rxWrite | input | 1 | Byte written toward the receive FIFO (pulse) |
| rxFull | input | 1 | Receive FIFO full (level) |
| statusRead | input | 1 | Status word read strobe |
| intEnable | input | 5 | Per-source interrupt enables |
| statusWord | output | 16 | Status word |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The transmit fields are swept over every combination of fill count and address-write state, so the bench can tell apart the occupancy code, which depends only on the count, from the request bit, which needs both the count and the address-write state. The interrupt combiner is tried with one source set at a time against all 32 enable patterns. A wrong bit-to-enable mapping shows up as a mismatch for some single source, and so does a shared-enable error on the two NACK kinds or an overflow that leaks into `irq`. Read strobes are issued both alone and in the same cycle as an event, which separates plain clear-on-read from the rule that the event wins. Start and stop are pulsed separately and then together to fix which one wins.

// File: rtl/i2cm_status_pkg.sv
`timescale 1ns/1ps
package i2cm_status_pkg;
  localparam int STATUS_W  = 16;
  localparam int N_STICKY  = 6;
  localparam int N_IRQ     = 5;
  localparam int TX_DEPTH  = 2;
  localparam int TX_CNT_W  = $clog2(TX_DEPTH + 1);

  // sticky flag indices
  localparam int S_DONE  = 0;
  localparam int S_DNACK = 1;
  localparam int S_ARB   = 2;
  localparam int S_ANACK = 3;
  localparam int S_RXREQ = 4;
  localparam int S_OVF   = 5;

  // status bit positions
  localparam int B_BUS   = 10;
  localparam int B_OVF   = 9;
  localparam int B_DONE  = 8;
  localparam int B_DNACK = 7;
  localparam int B_MBUSY = 6;
  localparam int B_ARB   = 5;
  localparam int B_ANACK = 4;
  localparam int B_RXREQ = 3;
  localparam int B_TXREQ = 2;

  typedef struct packed {
    logic                busSet;
    logic                busClr;
    logic [N_STICKY-1:0] stickySet;
    logic                stickyClr;
  } flag_strobe_t;
endpackage

// File: rtl/i2cm_status_ctrl.sv
`timescale 1ns/1ps
module i2cm_status_ctrl
  import i2cm_status_pkg::*;
(
  input  logic         startSeen,
  input  logic         stopSeen,
  input  logic         xferDone,
  input  logic         addrNack,
  input  logic         dataNack,
  input  logic         arbLost,
  input  logic         rxWrite,
  input  logic         rxFull,
  input  logic         statusRead,
  output flag_strobe_t strb
);
  always_comb begin
    strb                  = '0;
    strb.busSet           = startSeen;
    strb.busClr           = stopSeen & ~startSeen;
    strb.stickySet[S_DONE]  = xferDone;
    strb.stickySet[S_DNACK] = dataNack;
    strb.stickySet[S_ARB]   = arbLost;
    strb.stickySet[S_ANACK] = addrNack;
    strb.stickySet[S_RXREQ] = rxWrite & ~rxFull;
    strb.stickySet[S_OVF]   = rxWrite & rxFull;
    strb.stickyClr        = statusRead;
  end
endmodule

// File: rtl/i2cm_status_dp.sv
`timescale 1ns/1ps
module i2cm_status_dp
  import i2cm_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  flag_strobe_t        strb,
  input  logic                masterBusy,
  input  logic                addrWriteSent,
  input  logic [TX_CNT_W-1:0] txCount,
  input  logic [N_IRQ-1:0]    intEnable,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);
  logic [N_STICKY-1:0] stickyQ;
  logic                busBusyQ;
  logic                mBusyQ;
  logic                txReqQ;
  logic [1:0]          txCodeQ;
  logic [1:0]          txCodeD;
  logic [N_IRQ-1:0]    srcVec;
  logic                irqQ;

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)                   stickyQ[i] <= 1'b0;
      else if (strb.stickySet[i])  stickyQ[i] <= 1'b1;
      else if (strb.stickyClr)     stickyQ[i] <= 1'b0;
    end
  end

  always_comb begin
    if (txCount == '0)                              txCodeD = 2'b00;
    else if (txCount >= TX_CNT_W'(TX_DEPTH))        txCodeD = 2'b11;
    else                                            txCodeD = 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busBusyQ <= 1'b0;
      mBusyQ   <= 1'b0;
      txReqQ   <= 1'b0;
      txCodeQ  <= 2'b00;
    end else begin
      if (strb.busSet)      busBusyQ <= 1'b1;
      else if (strb.busClr) busBusyQ <= 1'b0;
      mBusyQ  <= masterBusy;
      txReqQ  <= addrWriteSent & (txCount <= TX_CNT_W'(1));
      txCodeQ <= txCodeD;
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[B_BUS]   = busBusyQ;
    statusWord[B_OVF]   = stickyQ[S_OVF];
    statusWord[B_DONE]  = stickyQ[S_DONE];
    statusWord[B_DNACK] = stickyQ[S_DNACK];
    statusWord[B_MBUSY] = mBusyQ;
    statusWord[B_ARB]   = stickyQ[S_ARB];
    statusWord[B_ANACK] = stickyQ[S_ANACK];
    statusWord[B_RXREQ] = stickyQ[S_RXREQ];
    statusWord[B_TXREQ] = txReqQ;
    statusWord[1:0]     = txCodeQ;
  end

  assign srcVec = {stickyQ[S_DONE], stickyQ[S_ARB],
                   stickyQ[S_DNACK] | stickyQ[S_ANACK],
                   stickyQ[S_RXREQ], txReqQ};

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(srcVec & intEnable);
  end

  assign irq = irqQ;
endmodule

// File: rtl/i2cm_status_top.sv
`timescale 1ns/1ps
module i2cm_status_top
  import i2cm_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startSeen,
  input  logic                stopSeen,
  input  logic                xferDone,
  input  logic                addrNack,
  input  logic                dataNack,
  input  logic                arbLost,
  input  logic                masterBusy,
  input  logic                addrWriteSent,
  input  logic [TX_CNT_W-1:0] txCount,
  input  logic                rxWrite,
  input  logic                rxFull,
  input  logic                statusRead,
  input  logic [N_IRQ-1:0]    intEnable,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);
  flag_strobe_t strb;

  i2cm_status_ctrl u_ctrl (
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .xferDone  (xferDone),
    .addrNack  (addrNack),
    .dataNack  (dataNack),
    .arbLost   (arbLost),
    .rxWrite   (rxWrite),
    .rxFull    (rxFull),
    .statusRead(statusRead),
    .strb      (strb)
  );

  i2cm_status_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .masterBusy   (masterBusy),
    .addrWriteSent(addrWriteSent),
    .txCount      (txCount),
    .intEnable    (intEnable),
    .statusWord   (statusWord),
    .irq          (irq)
  );
endmodule

// File: rtl/i2cm_status_chk.sv
`timescale 1ns/1ps
module i2cm_status_chk
  import i2cm_status_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                startSeen,
  input logic                stopSeen,
  input logic                xferDone,
  input logic                statusRead,
  input logic [N_IRQ-1:0]    intEnable,
  input logic [STATUS_W-1:0] statusWord,
  input logic                irq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[STATUS_W-1:11] == '0);

  p_bus_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> statusWord[B_BUS]);

  p_bus_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen) |=> !statusWord[B_BUS]);

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !xferDone) |=> !statusWord[B_DONE]);

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> statusWord[B_DONE]);

  p_tx_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[1:0] != 2'b10);

  p_irq_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[B_DONE] && intEnable[4]) |=> irq);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == '0) |=> !irq);
endmodule

bind i2cm_status_top i2cm_status_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startSeen (startSeen),
  .stopSeen  (stopSeen),
  .xferDone  (xferDone),
  .statusRead(statusRead),
  .intEnable (intEnable),
  .statusWord(statusWord),
  .irq       (irq)
);

// File: tb/sim_i2cm_status_top.sv
`timescale 1ns/1ps
module sim_i2cm_status_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSeen = 0, stopSeen = 0, xferDone = 0, addrNack = 0, dataNack = 0;
  logic arbLost = 0, masterBusy = 0, addrWriteSent = 0, rxWrite = 0, rxFull = 0;
  logic statusRead = 0;
  logic [1:0]  txCount = 2'd0;
  logic [4:0]  intEnable = 5'd0;
  logic [15:0] statusWord;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2cm_status_top u0 (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .xferDone(xferDone), .addrNack(addrNack), .dataNack(dataNack),
    .arbLost(arbLost), .masterBusy(masterBusy), .addrWriteSent(addrWriteSent),
    .txCount(txCount), .rxWrite(rxWrite), .rxFull(rxFull),
    .statusRead(statusRead), .intEnable(intEnable),
    .statusWord(statusWord), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    addrWriteSent = 0; txCount = 0; intEnable = 0; statusRead = 1;
    tick();
    statusRead = 0;
  endtask

  // set exactly one source, k: 0 tx,1 rx,2 dataNack,3 addrNack,4 arb,5 done,6 ovf
  task automatic setSource(input int k);
    clearAll();
    case (k)
      0: addrWriteSent = 1;
      1: rxWrite = 1;
      2: dataNack = 1;
      3: addrNack = 1;
      4: arbLost = 1;
      5: xferDone = 1;
      default: begin rxWrite = 1; rxFull = 1; end
    endcase
    tick();
    rxWrite = 0; rxFull = 0; dataNack = 0; addrNack = 0; arbLost = 0; xferDone = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset status", statusWord, 16'h0000);
    chk("R1 reset irq", {15'd0, irq}, 16'd0);
    rstN = 1;
    tick();

    // R2 bus busy
    startSeen = 1; tick(); startSeen = 0;
    chk("R2 start sets", {15'd0, statusWord[10]}, 16'd1);
    stopSeen = 1; tick(); stopSeen = 0;
    chk("R2 stop clears", {15'd0, statusWord[10]}, 16'd0);
    startSeen = 1; stopSeen = 1; tick(); startSeen = 0; stopSeen = 0;
    chk("R2 start wins", {15'd0, statusWord[10]}, 16'd1);
    stopSeen = 1; tick(); stopSeen = 0;

    // R9 / R10 sweep
    for (int a = 0; a < 2; a++) begin
      for (int c = 0; c < 3; c++) begin
        logic [2:0] e;
        addrWriteSent = a[0]; txCount = c[1:0];
        tick();
        e[2]   = (a == 1) && (c <= 1);
        e[1:0] = (c == 0) ? 2'b00 : (c == 2) ? 2'b11 : 2'b01;
        chk("R9 tx request", {15'd0, statusWord[2]}, {15'd0, e[2]});
        chk("R10 tx code", {14'd0, statusWord[1:0]}, {14'd0, e[1:0]});
        chk("R1 reserved", {11'd0, statusWord[15:11]}, 16'd0);
      end
    end
    addrWriteSent = 0; txCount = 0; tick();

    // R5 / R4
    xferDone = 1; tick(); xferDone = 0;
    chk("R5 done sets", {15'd0, statusWord[8]}, 16'd1);
    statusRead = 1; tick(); statusRead = 0;
    chk("R4 read clears done", {15'd0, statusWord[8]}, 16'd0);
    xferDone = 1; tick(); xferDone = 0;
    xferDone = 1; statusRead = 1; tick(); xferDone = 0; statusRead = 0;
    chk("R4 event beats read", {15'd0, statusWord[8]}, 16'd1);
    statusRead = 1; tick(); statusRead = 0;
    chk("R4 later read clears", {15'd0, statusWord[8]}, 16'd0);

    // R6
    dataNack = 1; tick(); dataNack = 0;
    chk("R6 data nack", {15'd0, statusWord[7]}, 16'd1);
    addrNack = 1; tick(); addrNack = 0;
    chk("R6 addr nack", {15'd0, statusWord[4]}, 16'd1);
    statusRead = 1; tick(); statusRead = 0;
    chk("R4 read clears nacks", {14'd0, statusWord[7], statusWord[4]}, 16'd0);

    // R7
    arbLost = 1; tick(); arbLost = 0;
    chk("R7 arb lost", {15'd0, statusWord[5]}, 16'd1);
    masterBusy = 1; tick();
    chk("R7 master busy high", {15'd0, statusWord[6]}, 16'd1);
    masterBusy = 0; tick();
    chk("R7 master busy low", {15'd0, statusWord[6]}, 16'd0);
    statusRead = 1; tick(); statusRead = 0;

    // R3 / R8
    rxWrite = 1; rxFull = 1; tick(); rxWrite = 0; rxFull = 0;
    chk("R3 overflow sets", {15'd0, statusWord[9]}, 16'd1);
    chk("R8 full write no request", {15'd0, statusWord[3]}, 16'd0);
    tick();
    chk("R3 overflow sticky", {15'd0, statusWord[9]}, 16'd1);
    rxWrite = 1; tick(); rxWrite = 0;
    chk("R8 rx request", {15'd0, statusWord[3]}, 16'd1);
    statusRead = 1; tick(); statusRead = 0;
    chk("R4 read clears rx flags", {14'd0, statusWord[9], statusWord[3]}, 16'd0);

    // R11 latency
    intEnable = 5'b10000;
    xferDone = 1; tick(); xferDone = 0;
    chk("R11 irq not yet", {15'd0, irq}, 16'd0);
    tick();
    chk("R11 irq one clock later", {15'd0, irq}, 16'd1);

    // R11 sweep: each single source against all enable patterns
    for (int k = 0; k < 7; k++) begin
      setSource(k);
      for (int en = 0; en < 32; en++) begin
        int bitIdx;
        logic e;
        intEnable = en[4:0];
        tick();
        bitIdx = (k == 0) ? 0 : (k == 1) ? 1 : (k <= 3) ? 2 : (k == 4) ? 3 : (k == 5) ? 4 : -1;
        e = (bitIdx < 0) ? 1'b0 : en[bitIdx];
        chk($sformatf("R11 src %0d en %0d", k, en), {15'd0, irq}, {15'd0, e});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule